// File: doc/BRIEF.md
# 8-bit Integer ALU with Selective Flag Update

This block is the arithmetic and logic stage of a small 8-bit core. Each cycle it may accept one operation: a 5-bit operation code, two operands and the current status byte. One clock later it returns the result, a write-enable for the destination register and the new status byte. Each operation rewrites only the flags that belong to it. The interrupt-enable and transfer bits always pass through unchanged.

Immediate forms of the instructions use the same operation codes as the register forms. The caller places the constant on `opB`. Single-operand operations read `opA`. Subtract-with-carry and compare-with-carry never set Z; they can only clear it. Software can therefore chain byte-wide subtractions or compares into a wider one, and the final Z flag reports whether the whole multi-byte value was zero.

Top module: `alu_core`

## Requirements
- R1: The status byte is laid out as bit7 I, bit6 T, bit5 H, bit4 S, bit3 V, bit2 N, bit1 Z, bit0 C. I and T are copied from `statusIn` to `statusOut` for every operation.
- R2: Add (code 0) returns opA+opB and add-with-carry (code 1) returns opA+opB+C. Both update Z, C, N, V and H. C is the carry out of bit 7, H is the carry out of bit 3, and V flags signed overflow.
- R3: Subtract (code 2) returns opA-opB and subtract-with-carry (code 3) returns opA-opB-C. Both update Z, C, N, V and H. C is the borrow out of bit 7 and H is the borrow out of bit 3.
- R4: Compare (code 4) and compare-with-carry (code 5) set the flags exactly as codes 2 and 3 would. They drive `writeEn` low, and `result` shows the difference.
- R5: For codes 3 and 5, a nonzero difference clears Z and a zero difference leaves the incoming Z unchanged.
- R6: AND (code 6), OR (code 7) and XOR (code 8) update Z, N and S, and force V to 0. C and H are unchanged.
- R7: One's complement (code 9) returns 0xFF-opA, forces C to 1 and V to 0, and leaves H unchanged. Two's complement (code 10) returns 0x00-opA, sets C when the result is nonzero, sets V only for 0x80, and sets H from the borrow out of bit 3.
- R8: Increment (code 11) and decrement (code 12) update Z, N, V and S and leave C and H unchanged. Increment sets V only when opA is 0x7F. Decrement sets V only when opA is 0x80.
- R9: The shift and rotate codes are:
  - code 13, shift left, fills bit 0 with 0;
  - code 14, logical shift right, fills bit 7 with 0;
  - code 15, arithmetic shift right, keeps bit 7;
  - code 16, rotate left through carry;
  - code 17, rotate right through carry.

  For all five, C takes the bit shifted out and V = N xor C. H is unchanged.
- R10: Nibble swap (code 18) exchanges bits 7:4 with bits 3:0, writes back, and leaves the status byte unchanged.
- R11: S equals N xor V after every operation with codes 0 to 17.
- R12: Outputs are registered. `resValid` follows `inValid` one cycle later, and `writeEn` is low whenever `resValid` is low. After reset all outputs are zero.
- R13: Codes 19 to 31 are unused. They return a zero result with `writeEn` low and copy the status byte through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| opcode | input | 5 | Operation code (see requirements) |
| opA | input | 8 | First operand, also the single operand |
| opB | input | 8 | Second operand or immediate constant |
| statusIn | input | 8 | Current status byte |
| resValid | output | 1 | Result of the previous cycle's operation is present |
| result | output | 8 | Operation result |
| writeEn | output | 1 | Result must be written to the destination |
| statusOut | output | 8 | Updated status byte |

## Verification
The bench targets the cases where flag rules are easy to get wrong:
- **Half carry and half borrow.** It uses operands that cross bit 3. A design that tests the wrong nibble bit, or uses the addition formula for subtraction, reports a wrong H.
- **Signed overflow.** It places operands at the 0x7F/0x80 boundary for add, subtract, negate, increment and decrement. A misplaced overflow equation shows up here, in V and therefore also in S.
- **Zero chaining.** It runs subtract-with-carry and compare-with-carry with the incoming Z both set and clear. A design that recomputes Z from scratch breaks multi-byte compares.
- **Flags that must stay put.** It checks that logic operations and increment/decrement preserve carry, that rotates inject the old carry, and that swap leaves every flag alone. An over-eager flag mask fails these.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int ST_W = 8;
  localparam int ST_C = 0;
  localparam int ST_Z = 1;
  localparam int ST_N = 2;
  localparam int ST_V = 3;
  localparam int ST_S = 4;
  localparam int ST_H = 5;
  localparam int ST_T = 6;
  localparam int ST_I = 7;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR = 5'd14, OP_ASR = 5'd15,
    OP_ROL  = 5'd16, OP_ROR  = 5'd17, OP_SWAP = 5'd18
  } aluOpE;

  typedef enum logic [2:0] {
    U_NONE, U_ADD, U_SUB, U_LOGIC, U_COM, U_INCDEC, U_SHIFT, U_SWAP
  } unitE;

  typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR } logicE;

  typedef enum logic [2:0] { SH_LSL, SH_LSR, SH_ASR, SH_ROL, SH_ROR } shiftE;

  typedef struct packed {
    unitE  unitSel;
    logicE logicSel;
    shiftE shiftSel;
    logic  useCarry;
    logic  zeroMinuend;
    logic  incNotDec;
    logic  zChain;
    logic  wrEn;
    logic  updZnvs;
    logic  updC;
    logic  updH;
  } ctrlStrobeT;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrlStrobeT      strb
);
  always_comb begin
    strb = '0;
    strb.unitSel  = U_NONE;
    strb.logicSel = LG_AND;
    strb.shiftSel = SH_LSL;
    case (aluOpE'(opcode))
      OP_ADD, OP_ADC: begin
        strb.unitSel  = U_ADD;
        strb.useCarry = (aluOpE'(opcode) == OP_ADC);
        strb.wrEn = 1'b1; strb.updZnvs = 1'b1; strb.updC = 1'b1; strb.updH = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
        strb.unitSel  = U_SUB;
        strb.useCarry = (aluOpE'(opcode) == OP_SBC) || (aluOpE'(opcode) == OP_CMPC);
        strb.zChain   = strb.useCarry;
        strb.wrEn     = (aluOpE'(opcode) == OP_SUB) || (aluOpE'(opcode) == OP_SBC);
        strb.updZnvs = 1'b1; strb.updC = 1'b1; strb.updH = 1'b1;
      end
      OP_NEG: begin
        strb.unitSel = U_SUB; strb.zeroMinuend = 1'b1;
        strb.wrEn = 1'b1; strb.updZnvs = 1'b1; strb.updC = 1'b1; strb.updH = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strb.unitSel  = U_LOGIC;
        strb.logicSel = (aluOpE'(opcode) == OP_AND) ? LG_AND :
                        (aluOpE'(opcode) == OP_OR)  ? LG_OR : LG_XOR;
        strb.wrEn = 1'b1; strb.updZnvs = 1'b1;
      end
      OP_COM: begin
        strb.unitSel = U_COM;
        strb.wrEn = 1'b1; strb.updZnvs = 1'b1; strb.updC = 1'b1;
      end
      OP_INC, OP_DEC: begin
        strb.unitSel   = U_INCDEC;
        strb.incNotDec = (aluOpE'(opcode) == OP_INC);
        strb.wrEn = 1'b1; strb.updZnvs = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
        strb.unitSel = U_SHIFT;
        case (aluOpE'(opcode))
          OP_LSL:  strb.shiftSel = SH_LSL;
          OP_LSR:  strb.shiftSel = SH_LSR;
          OP_ASR:  strb.shiftSel = SH_ASR;
          OP_ROL:  strb.shiftSel = SH_ROL;
          default: strb.shiftSel = SH_ROR;
        endcase
        strb.wrEn = 1'b1; strb.updZnvs = 1'b1; strb.updC = 1'b1;
      end
      OP_SWAP: begin
        strb.unitSel = U_SWAP; strb.wrEn = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  ctrlStrobeT       strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [ST_W-1:0]  statusIn,
  output logic             resValid,
  output logic [WIDTH-1:0] result,
  output logic             writeEn,
  output logic [ST_W-1:0]  statusOut
);
  localparam int MSB = WIDTH - 1;
  localparam int HB  = WIDTH / 2 - 1;
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {MSB{1'b1}}};
  localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {MSB{1'b0}}};

  logic [WIDTH:0]   sumW, difW;
  logic [WIDTH-1:0] minuend, subtrahend, res;
  logic             cin, cOld, cNew, hNew, vNew, nNew, zNew;
  logic [ST_W-1:0]  stNext;

  always_comb begin
    cOld       = statusIn[ST_C];
    cin        = strb.useCarry & cOld;
    minuend    = strb.zeroMinuend ? '0 : opA;
    subtrahend = strb.zeroMinuend ? opA : opB;
    sumW = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, cin};
    difW = {1'b0, minuend} - {1'b0, subtrahend} - {{WIDTH{1'b0}}, cin};
    res  = '0;
    cNew = cOld;
    hNew = statusIn[ST_H];
    vNew = 1'b0;
    case (strb.unitSel)
      U_ADD: begin
        res  = sumW[MSB:0];
        cNew = sumW[WIDTH];
        hNew = (opA[HB] & opB[HB]) | (opB[HB] & ~res[HB]) | (~res[HB] & opA[HB]);
        vNew = (opA[MSB] & opB[MSB] & ~res[MSB]) | (~opA[MSB] & ~opB[MSB] & res[MSB]);
      end
      U_SUB: begin
        res  = difW[MSB:0];
        cNew = difW[WIDTH];
        hNew = (~minuend[HB] & subtrahend[HB]) | (subtrahend[HB] & res[HB]) |
               (res[HB] & ~minuend[HB]);
        vNew = (minuend[MSB] & ~subtrahend[MSB] & ~res[MSB]) |
               (~minuend[MSB] & subtrahend[MSB] & res[MSB]);
      end
      U_LOGIC: begin
        case (strb.logicSel)
          LG_AND:  res = opA & opB;
          LG_OR:   res = opA | opB;
          default: res = opA ^ opB;
        endcase
      end
      U_COM: begin
        res  = ~opA;
        cNew = 1'b1;
      end
      U_INCDEC: begin
        res  = strb.incNotDec ? opA + 1'b1 : opA - 1'b1;
        vNew = strb.incNotDec ? (opA == MAX_POS) : (opA == MIN_NEG);
      end
      U_SHIFT: begin
        case (strb.shiftSel)
          SH_LSL:  begin res = {opA[MSB-1:0], 1'b0};     cNew = opA[MSB]; end
          SH_LSR:  begin res = {1'b0, opA[MSB:1]};       cNew = opA[0];   end
          SH_ASR:  begin res = {opA[MSB], opA[MSB:1]};   cNew = opA[0];   end
          SH_ROL:  begin res = {opA[MSB-1:0], cOld};     cNew = opA[MSB]; end
          default: begin res = {cOld, opA[MSB:1]};       cNew = opA[0];   end
        endcase
        vNew = res[MSB] ^ cNew;
      end
      U_SWAP: res = {opA[HB:0], opA[MSB:HB+1]};
      default: res = '0;
    endcase
    nNew = res[MSB];
    zNew = (res == '0) & (~strb.zChain | statusIn[ST_Z]);

    stNext = statusIn;
    if (strb.updZnvs) begin
      stNext[ST_Z] = zNew;
      stNext[ST_N] = nNew;
      stNext[ST_V] = vNew;
      stNext[ST_S] = nNew ^ vNew;
    end
    if (strb.updC) stNext[ST_C] = cNew;
    if (strb.updH) stNext[ST_H] = hNew;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      result    <= '0;
      writeEn   <= 1'b0;
      statusOut <= '0;
    end else begin
      resValid <= inValid;
      writeEn  <= inValid & strb.wrEn;
      if (inValid) begin
        result    <= res;
        statusOut <= stNext;
      end
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OP_W-1:0]  opcode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [ST_W-1:0]  statusIn,
  output logic             resValid,
  output logic [WIDTH-1:0] result,
  output logic             writeEn,
  output logic [ST_W-1:0]  statusOut
);
  ctrlStrobeT strb;

  alu_ctrl u_ctrl (
    .opcode (opcode),
    .strb   (strb)
  );

  alu_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .statusIn  (statusIn),
    .resValid  (resValid),
    .result    (result),
    .writeEn   (writeEn),
    .statusOut (statusOut)
  );
endmodule

// File: rtl/alu_checker.sv
module alu_checker
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [OP_W-1:0]  opcode,
  input logic [WIDTH-1:0] opA,
  input logic [ST_W-1:0]  statusIn,
  input logic             resValid,
  input logic [WIDTH-1:0] result,
  input logic             writeEn,
  input logic [ST_W-1:0]  statusOut
);
  localparam int HB = WIDTH / 2 - 1;

  assert_valid_R12: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(inValid));

  assert_wren_R12: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !writeEn);

  assert_it_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> statusOut[ST_I:ST_T] == $past(statusIn[ST_I:ST_T]));

  assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && ($past(opcode) == OP_CMP || $past(opcode) == OP_CMPC)) |-> !writeEn);

  assert_keep_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && ($past(opcode) >= OP_AND) && ($past(opcode) <= OP_XOR))
      |-> statusOut[ST_C] == $past(statusIn[ST_C]) && !statusOut[ST_V]);

  assert_com_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(opcode) == OP_COM)
      |-> statusOut[ST_C] && !statusOut[ST_V] && result == ~$past(opA));

  assert_swap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(opcode) == OP_SWAP)
      |-> statusOut == $past(statusIn) &&
          result == {$past(opA[HB:0]), $past(opA[WIDTH-1:HB+1])});

  assert_sign_R11: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(opcode) <= OP_ROR)
      |-> statusOut[ST_S] == (statusOut[ST_N] ^ statusOut[ST_V]));

  assert_unused_R13: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(opcode) > OP_SWAP)
      |-> !writeEn && statusOut == $past(statusIn));
endmodule

bind alu_core alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opcode    (opcode),
  .opA       (opA),
  .statusIn  (statusIn),
  .resValid  (resValid),
  .result    (result),
  .writeEn   (writeEn),
  .statusOut (statusOut)
);

// File: tb/tb_alu_core.sv
`timescale 1ns/1ps
module tb_alu_core;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [4:0] opcode = '0;
  logic [7:0] opA = '0, opB = '0, statusIn = '0;
  logic       resValid, writeEn;
  logic [7:0] result, statusOut;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_core dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .statusIn(statusIn),
    .resValid(resValid), .result(result), .writeEn(writeEn), .statusOut(statusOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] st,
                       input logic [7:0] expRes, input logic expWe, input logic [7:0] expSt);
    @(negedge clk);
    opcode = op; opA = a; opB = b; statusIn = st; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk({tag, " valid"},  {7'd0, resValid}, 8'd1);
    chk({tag, " result"}, result, expRes);
    chk({tag, " wren"},   {7'd0, writeEn}, {7'd0, expWe});
    chk({tag, " status"}, statusOut, expSt);
  endtask

  task automatic testReset;
    chk("R12 reset valid",  {7'd0, resValid}, 8'd0);
    chk("R12 reset result", result, 8'd0);
    chk("R12 reset wren",   {7'd0, writeEn}, 8'd0);
    chk("R12 reset status", statusOut, 8'd0);
  endtask

  task automatic testAdd;
    runOp("R2 R1 add half", 5'd0, 8'h0F, 8'h01, 8'hC0, 8'h10, 1, 8'hE0);
    runOp("R2 R11 add ovf", 5'd0, 8'h80, 8'h80, 8'h00, 8'h00, 1, 8'h1B);
    runOp("R2 adc cin",     5'd1, 8'h7F, 8'h00, 8'h01, 8'h80, 1, 8'h2C);
  endtask

  task automatic testSub;
    runOp("R3 sub half", 5'd2, 8'h10, 8'h01, 8'h00, 8'h0F, 1, 8'h20);
    runOp("R3 sub wrap", 5'd2, 8'h00, 8'h01, 8'h00, 8'hFF, 1, 8'h35);
    runOp("R3 R11 sub ovf", 5'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 1, 8'h38);
  endtask

  task automatic testCmp;
    runOp("R4 cmp eq", 5'd4, 8'h05, 8'h05, 8'h80, 8'h00, 0, 8'h82);
    runOp("R4 cmp lt", 5'd4, 8'h03, 8'h05, 8'h00, 8'hFE, 0, 8'h35);
  endtask

  task automatic testChain;
    runOp("R5 sub low", 5'd2, 8'h00, 8'h00, 8'h00, 8'h00, 1, 8'h02);
    runOp("R5 sbc keepz", 5'd3, 8'h01, 8'h01, 8'h02, 8'h00, 1, 8'h02);
    runOp("R5 cpc zclear stays", 5'd5, 8'h01, 8'h01, 8'h00, 8'h00, 0, 8'h00);
    runOp("R5 sbc nonzero", 5'd3, 8'h05, 8'h02, 8'h03, 8'h02, 1, 8'h00);
    runOp("R5 R4 cpc borrow", 5'd5, 8'h00, 8'h00, 8'h03, 8'hFF, 0, 8'h35);
  endtask

  task automatic testLogic;
    runOp("R6 and", 5'd6, 8'hF0, 8'h3C, 8'h2B, 8'h30, 1, 8'h21);
    runOp("R6 or",  5'd7, 8'h80, 8'h01, 8'h08, 8'h81, 1, 8'h14);
    runOp("R6 xor", 5'd8, 8'h5A, 8'h5A, 8'h00, 8'h00, 1, 8'h02);
  endtask

  task automatic testComNeg;
    runOp("R7 com",    5'd9,  8'h0F, 8'h00, 8'h00, 8'hF0, 1, 8'h15);
    runOp("R7 neg 01", 5'd10, 8'h01, 8'h00, 8'h00, 8'hFF, 1, 8'h35);
    runOp("R7 neg 80", 5'd10, 8'h80, 8'h00, 8'h00, 8'h80, 1, 8'h0D);
    runOp("R7 neg 00", 5'd10, 8'h00, 8'h00, 8'h00, 8'h00, 1, 8'h02);
  endtask

  task automatic testIncDec;
    runOp("R8 inc 7f", 5'd11, 8'h7F, 8'h00, 8'h21, 8'h80, 1, 8'h2D);
    runOp("R8 inc ff", 5'd11, 8'hFF, 8'h00, 8'h00, 8'h00, 1, 8'h02);
    runOp("R8 dec 80", 5'd12, 8'h80, 8'h00, 8'h01, 8'h7F, 1, 8'h19);
  endtask

  task automatic testShift;
    runOp("R9 lsl", 5'd13, 8'h81, 8'h00, 8'h20, 8'h02, 1, 8'h39);
    runOp("R9 lsr", 5'd14, 8'h01, 8'h00, 8'h00, 8'h00, 1, 8'h1B);
    runOp("R9 asr", 5'd15, 8'h81, 8'h00, 8'h00, 8'hC0, 1, 8'h15);
    runOp("R9 rol", 5'd16, 8'h80, 8'h00, 8'h01, 8'h01, 1, 8'h19);
    runOp("R9 ror", 5'd17, 8'h02, 8'h00, 8'h01, 8'h81, 1, 8'h0C);
  endtask

  task automatic testSwapUnused;
    runOp("R10 swap", 5'd18, 8'hA5, 8'h00, 8'hFF, 8'h5A, 1, 8'hFF);
    runOp("R13 unused", 5'd31, 8'h33, 8'h44, 8'h5A, 8'h00, 0, 8'h5A);
  endtask

  task automatic testIdle;
    @(negedge clk);
    chk("R12 idle valid", {7'd0, resValid}, 8'd0);
    chk("R12 idle wren",  {7'd0, writeEn}, 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testAdd();
    testSub();
    testCmp();
    testChain();
    testLogic();
    testComNeg();
    testIncDec();
    testShift();
    testSwapUnused();
    testIdle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule